// File: doc/BRIEF.md
# Two-Level SMI Status and Power-Down Control Register

This block is a 32-bit control and status register that sits beside a low-pin-count bus bridge. It latches two event sources as sticky second-level SMI status bits. The first source is a serial-interrupt event pulse and the second is a bus-error pulse. A single shared top-level status flag tracks them, and the block raises an SMI request while that flag is set. A third sticky bit records a repeated bus error. Software clears each status bit by writing a one to it.

The same register also selects the active-low bus power-down output. The output either follows an ACPI-driven input or takes a value that software supplies. A read-only bit returns the live level of that output.

The top-level flag is a two-state machine:
- **TOP_IDLE**: no SMI is pending.
- **TOP_PENDING**: an SMI is requested.

It has two transitions:
- **SET_EVT** (TOP_IDLE to TOP_PENDING): a second-level status bit sets.
- **CLEAR_W1C** (TOP_PENDING to TOP_IDLE): a write-one-to-clear on either second-level bit leaves both second-level bits clear and no event sets one in that cycle.

In every other case the state holds.

Top module: `smi_status_reg`

## Requirements
- R1: After reset, with `acpi_pd_n_i` high, the register reads 0x00000080 and `smi_o` and `top_smi_stat_o` are 0. Bits 31:12 always read zero.
- R2: With bit 11 at 0, `pd_n_o` equals `acpi_pd_n_i`. With bit 11 at 1, `pd_n_o` equals bit 10, where 0 requests power-down and 1 means normal power.
- R3: Bit 7 reads the current level of `pd_n_o`, and writes to bit 7 have no effect.
- R4: A serial-interrupt pulse sets bit 6 only while bit 9 is 1. When bit 9 is 0 the pulse changes nothing.
- R5: A bus-error pulse sets bit 5 only while bit 8 is 1. When bit 8 is 0 the pulse changes nothing.
- R6: A bus-error pulse that arrives while bit 5 is already set sets bit 4. Writing 1 to bit 4 clears it.
- R7: Whenever bit 6 or bit 5 sets, the top-level status becomes 1. `smi_o` is 1 exactly while the top-level status is 1.
- R8: Writing 1 to bit 6 or bit 5 clears that bit. The top-level status clears only if both bit 6 and bit 5 are 0 after the write, so writing 1 to both at once clears all three.
- R9: When an event and a write of 1 hit the same status bit in one cycle, the bit ends up set, and so does the top-level status.
- R10: Writes are applied per byte lane under `wr_be`. A lane that is not enabled leaves its bits unchanged. Writes to bits 31:12 and to bit 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 4 | Byte-lane enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents, read combinationally |
| serirq_evt_i | input | 1 | Single-cycle serial-interrupt event |
| buserr_evt_i | input | 1 | Single-cycle bus-error event |
| acpi_pd_n_i | input | 1 | Power-down level from ACPI logic, active low |
| pd_n_o | output | 1 | Bus power-down output, active low |
| top_smi_stat_o | output | 1 | Shared top-level SMI status |
| smi_o | output | 1 | SMI request |

## Verification
The assertions check four things on every cycle:
- The set-wins priority inside each sticky bit.
- That a rising second-level bit always puts the top-level flag into TOP_PENDING.
- That the top-level flag never falls while a second-level bit remains set.
- That a repeated bus error raises the multiple-error bit.

Some behaviours can only be shown by the bench's scenarios:
- The asymmetric clear, where one bit is cleared while the other is still set.
- Byte-lane masking and the ignored reserved and read-only bits.
- The power-down source selection and its readback through bit 7.

// File: rtl/smi_pkg.sv
package smi_pkg;
    localparam int REG_W       = 32;
    localparam int BE_W        = REG_W / 8;
    localparam int BIT_OVR_EN  = 11;
    localparam int BIT_OVR_VAL = 10;
    localparam int BIT_IRQ_EN  = 9;
    localparam int BIT_ERR_EN  = 8;
    localparam int BIT_PIN     = 7;
    localparam int BIT_IRQ_ST  = 6;
    localparam int BIT_ERR_ST  = 5;
    localparam int BIT_MULTI   = 4;
    localparam int N_STICKY    = 3;
    localparam int IDX_MULTI   = 0;
    localparam int IDX_ERR     = 1;
    localparam int IDX_IRQ     = 2;

    typedef enum logic {
        TOP_IDLE    = 1'b0,
        TOP_PENDING = 1'b1
    } top_state_e;
endpackage

// File: rtl/smi_sticky_bit.sv
module smi_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     q_q <= 1'b0;
        else if (set_i) q_q <= 1'b1;
        else if (clr_i) q_q <= 1'b0;
    end

    assign q_o = q_q;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

    // R8
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/smi_top_fsm.sv
module smi_top_fsm
    import smi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_req_i,
    input  logic others_clear_i,
    output logic pending_o
);
    top_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TOP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TOP_IDLE:    if (set_i) state_d = TOP_PENDING;
            TOP_PENDING: if (!set_i && clr_req_i && others_clear_i) state_d = TOP_IDLE;
            default:     state_d = TOP_IDLE;
        endcase
    end

    always_comb begin
        pending_o = (state_q == TOP_PENDING);
    end

    // R7
    set_enters_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pending_o);
endmodule

// File: rtl/smi_pd_mux.sv
module smi_pd_mux (
    input  logic ovr_en_i,
    input  logic ovr_val_i,
    input  logic acpi_pd_n_i,
    output logic pd_n_o
);
    always_comb begin
        pd_n_o = ovr_en_i ? ovr_val_i : acpi_pd_n_i;
    end
endmodule

// File: rtl/smi_status_reg.sv
module smi_status_reg
    import smi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BE_W-1:0]  wr_be,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             serirq_evt_i,
    input  logic             buserr_evt_i,
    input  logic             acpi_pd_n_i,
    output logic             pd_n_o,
    output logic             top_smi_stat_o,
    output logic             smi_o
);
    logic ovr_en_q, ovr_val_q, irq_en_q, err_en_q;
    logic ctl_wr, st_wr;
    logic [N_STICKY-1:0] set_vec, clr_vec, q_vec;
    logic irq_next, err_next, others_clear, clr_req, set_any, pending;

    assign ctl_wr = wr_en && wr_be[BIT_ERR_EN/8];
    assign st_wr  = wr_en && wr_be[BIT_IRQ_ST/8];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_en_q  <= 1'b0;
            ovr_val_q <= 1'b0;
            irq_en_q  <= 1'b0;
            err_en_q  <= 1'b0;
        end else if (ctl_wr) begin
            ovr_en_q  <= wr_data[BIT_OVR_EN];
            ovr_val_q <= wr_data[BIT_OVR_VAL];
            irq_en_q  <= wr_data[BIT_IRQ_EN];
            err_en_q  <= wr_data[BIT_ERR_EN];
        end
    end

    always_comb begin
        set_vec[IDX_IRQ]   = serirq_evt_i && irq_en_q;
        set_vec[IDX_ERR]   = buserr_evt_i && err_en_q;
        set_vec[IDX_MULTI] = buserr_evt_i && q_vec[IDX_ERR];
        clr_vec[IDX_IRQ]   = st_wr && wr_data[BIT_IRQ_ST];
        clr_vec[IDX_ERR]   = st_wr && wr_data[BIT_ERR_ST];
        clr_vec[IDX_MULTI] = st_wr && wr_data[BIT_MULTI];
    end

    for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
        smi_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[i]),
            .clr_i (clr_vec[i]),
            .q_o   (q_vec[i])
        );
    end

    always_comb begin
        irq_next     = set_vec[IDX_IRQ] || (q_vec[IDX_IRQ] && !clr_vec[IDX_IRQ]);
        err_next     = set_vec[IDX_ERR] || (q_vec[IDX_ERR] && !clr_vec[IDX_ERR]);
        others_clear = !irq_next && !err_next;
        clr_req      = clr_vec[IDX_IRQ] || clr_vec[IDX_ERR];
        set_any      = set_vec[IDX_IRQ] || set_vec[IDX_ERR];
    end

    smi_top_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .set_i          (set_any),
        .clr_req_i      (clr_req),
        .others_clear_i (others_clear),
        .pending_o      (pending)
    );

    smi_pd_mux u_pd (
        .ovr_en_i    (ovr_en_q),
        .ovr_val_i   (ovr_val_q),
        .acpi_pd_n_i (acpi_pd_n_i),
        .pd_n_o      (pd_n_o)
    );

    always_comb begin
        rd_data              = '0;
        rd_data[BIT_OVR_EN]  = ovr_en_q;
        rd_data[BIT_OVR_VAL] = ovr_val_q;
        rd_data[BIT_IRQ_EN]  = irq_en_q;
        rd_data[BIT_ERR_EN]  = err_en_q;
        rd_data[BIT_PIN]     = pd_n_o;
        rd_data[BIT_IRQ_ST]  = q_vec[IDX_IRQ];
        rd_data[BIT_ERR_ST]  = q_vec[IDX_ERR];
        rd_data[BIT_MULTI]   = q_vec[IDX_MULTI];
    end

    assign top_smi_stat_o = pending;
    assign smi_o          = pending;

    // R7
    err_rise_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_vec[IDX_ERR]) |-> top_smi_stat_o);

    // R8
    top_fall_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(top_smi_stat_o) |-> (!q_vec[IDX_IRQ] && !q_vec[IDX_ERR]));

    // R6
    multi_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buserr_evt_i && q_vec[IDX_ERR]) |=> q_vec[IDX_MULTI]);
endmodule

// File: tb/smi_status_reg_bench.sv
module smi_status_reg_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        serirq_evt_i = 1'b0;
    logic        buserr_evt_i = 1'b0;
    logic        acpi_pd_n_i = 1'b1;
    logic        pd_n_o, top_smi_stat_o, smi_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] q_rd[$];
    logic        q_smi[$];
    logic        q_pd[$];
    string       q_req[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    smi_status_reg u_smi_status_reg (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_be          (wr_be),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .serirq_evt_i   (serirq_evt_i),
        .buserr_evt_i   (buserr_evt_i),
        .acpi_pd_n_i    (acpi_pd_n_i),
        .pd_n_o         (pd_n_o),
        .top_smi_stat_o (top_smi_stat_o),
        .smi_o          (smi_o)
    );

    task automatic step(input logic w, input logic [3:0] be, input logic [31:0] d,
                        input logic irq, input logic err, input logic acpi,
                        input logic [31:0] erd, input logic esmi, input logic epd,
                        input string req);
        @(negedge clk);
        wr_en = w; wr_be = be; wr_data = d;
        serirq_evt_i = irq; buserr_evt_i = err; acpi_pd_n_i = acpi;
        q_rd.push_back(erd); q_smi.push_back(esmi);
        q_pd.push_back(epd); q_req.push_back(req);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q_rd.size() > 0) begin
                logic [31:0] erd;
                logic esmi, epd;
                string req;
                erd = q_rd.pop_front(); esmi = q_smi.pop_front();
                epd = q_pd.pop_front(); req = q_req.pop_front();
                checks++;
                if (rd_data !== erd || smi_o !== esmi || top_smi_stat_o !== esmi || pd_n_o !== epd) begin
                    failures++;
                    $display("FAIL %s: rd=%h smi=%b top=%b pd=%b expected rd=%h smi=%b pd=%b",
                             req, rd_data, smi_o, top_smi_stat_o, pd_n_o, erd, esmi, epd);
                end
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset value
        step(0, 4'h0, 32'h0, 0, 0, 1, 32'h0000_0080, 0, 1, "R1");
        // enable both sources
        step(1, 4'h2, 32'h0000_0300, 0, 0, 1, 32'h0000_0380, 0, 1, "R10");
        // R4 / R7 serial event sets bit 6 and the top level
        step(0, 4'h0, 32'h0, 1, 0, 1, 32'h0000_03C0, 1, 1, "R4");
        // R5 bus error sets bit 5
        step(0, 4'h0, 32'h0, 0, 1, 1, 32'h0000_03E0, 1, 1, "R5");
        // R6 second error sets bit 4
        step(0, 4'h0, 32'h0, 0, 1, 1, 32'h0000_03F0, 1, 1, "R6");
        step(1, 4'h1, 32'h0000_0010, 0, 0, 1, 32'h0000_03E0, 1, 1, "R6");
        // R8 clearing bit 6 while bit 5 set keeps top
        step(1, 4'h1, 32'h0000_0040, 0, 0, 1, 32'h0000_03A0, 1, 1, "R8");
        // R8 clearing bit 5 with bit 6 clear drops top
        step(1, 4'h1, 32'h0000_0020, 0, 0, 1, 32'h0000_0380, 0, 1, "R8");
        // R9 event and clear together
        step(1, 4'h1, 32'h0000_0040, 1, 0, 1, 32'h0000_03C0, 1, 1, "R9");
        step(1, 4'h1, 32'h0000_0040, 0, 0, 1, 32'h0000_0380, 0, 1, "R8");
        // R3 / R10 writing bit 7 and the whole low byte changes nothing
        step(1, 4'h1, 32'hFFFF_FFFF, 0, 0, 1, 32'h0000_0380, 0, 1, "R3");
        // disable sources; events ignored
        step(1, 4'h2, 32'h0000_0000, 0, 0, 1, 32'h0000_0080, 0, 1, "R10");
        step(0, 4'h0, 32'h0, 1, 0, 1, 32'h0000_0080, 0, 1, "R4");
        step(0, 4'h0, 32'h0, 0, 1, 1, 32'h0000_0080, 0, 1, "R5");
        // R2 ACPI pass-through, R3 readback
        step(0, 4'h0, 32'h0, 0, 0, 0, 32'h0000_0000, 0, 0, "R2");
        // R2 override to power-down
        step(1, 4'h2, 32'h0000_0800, 0, 0, 1, 32'h0000_0800, 0, 0, "R2");
        // R2 override to normal power with ACPI low
        step(1, 4'h2, 32'h0000_0C00, 0, 0, 0, 32'h0000_0C80, 0, 1, "R2");
        // R10 reserved bits ignored, upper lanes written
        step(1, 4'hE, 32'hFFFF_F300, 0, 0, 1, 32'h0000_0380, 0, 1, "R10");
        // R7 both events at once
        step(0, 4'h0, 32'h0, 1, 1, 1, 32'h0000_03E0, 1, 1, "R7");
        // R10 disabled lane does not clear
        step(1, 4'h0, 32'h0000_0060, 0, 0, 1, 32'h0000_03E0, 1, 1, "R10");
        // R8 clearing both together drops top
        step(1, 4'h1, 32'h0000_0060, 0, 0, 1, 32'h0000_0380, 0, 1, "R8");
        step(0, 4'h0, 32'h0, 0, 0, 1, 32'h0000_0380, 0, 1, "R1");
        @(negedge clk);
        wr_en = 1'b0; serirq_evt_i = 1'b0; buserr_evt_i = 1'b0;
        while (q_rd.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule